// File: doc/BRIEF.md
# Two-Dimensional Parity Block Coder

This block protects a small fixed-size information block with a row-and-column even-parity code. The encoder places twelve information bits into a grid of three rows of four bits, filling it row by row. It appends a parity bit to each row and adds a parity row under the grid, which gives a 20-bit code word. The checker takes a received 20-bit word and recomputes every row check and every column check. A single flipped bit makes exactly one row check and one column check fail. The checker uses that crossing point to find the bit and repair the information it returns.

The encoder and the checker are independent paths with separate valid/ready handshakes. Each path is a small two-state holding stage. In `ST_EMPTY` the path accepts input. The *accept* transition moves it to `ST_FULL` when the input valid is high. In `ST_FULL` the path presents its registered result. The *release* transition returns it to `ST_EMPTY` when the output ready is high. A result therefore appears on the cycle after its input handshake. A pattern of failing checks that does not point to a single bit is reported as uncorrectable, and the information bits pass through unchanged.

Top module: `lvp_codec`

## Requirements
- R1: Bit order and parity rule.
  - Information bit 11 is row 0, column 0, and the grid fills row by row.
  - The code word is sent MSB first, five bits per row. Transmitted index t (0 = bit 19) sits at row t/5, column t%5.
  - Column 4 of rows 0 to 2 holds the row parity, and row 3 holds the column parity. Bit 0 is the corner bit, the parity of row 3.
  - All parity is even, so every emitted word has an even number of ones.
- R2: Information 12'b101101101011 encodes to 20'b10111_01100_10111_01100. All zeros encodes to all zeros.
- R3: Encoder handshake.
  - `enc_in_ready` is high only while the encoder stage is empty.
  - `enc_out_valid` rises on the cycle after an accepted input.
  - While `enc_out_ready` is low, `enc_word` holds stable, `enc_out_valid` stays high and further input has no effect.
- R4: A received word with no failing check gives `err_detected`=0, `err_corrected`=0, `err_uncorr`=0, `err_pos`=0, and `chk_info` equal to the information positions of the word.
- R5: A single flipped information bit at transmitted index t is handled as follows.
  - `err_detected`=1, `err_corrected`=1 and `err_pos`=t.
  - `chk_info` returns the original information.
  - Example: flipping index 7 of the R2 word fails the check of row 1 and of column 2.
- R6: A single flipped row-parity or column-parity bit gives `err_detected`=1, `err_corrected`=1, `err_pos` equal to its index, and `chk_info` unchanged.
- R7: A flip of only the corner bit (index 19) is reported as a parity-bit error: `err_corrected`=1, `err_pos`=19, and the information is unchanged.
- R8: Uncorrectable patterns:
  - only row checks fail;
  - only column checks fail;
  - more than one row check fails;
  - more than one column check fails.

  Each of these gives `err_detected`=1, `err_uncorr`=1, `err_corrected`=0, `err_pos`=0, and applies no correction.
- R9: Checker handshake.
  - `chk_in_ready` is high only while the checker stage is empty.
  - `chk_out_valid` rises on the cycle after an accepted input.
  - Results stay stable while `chk_out_ready` is low.
- R10: After reset, both input readies are high and both output valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_in_valid | input | 1 | Encoder input valid |
| enc_in_ready | output | 1 | Encoder can accept |
| enc_info | input | 12 | Information block to encode |
| enc_out_valid | output | 1 | Code word valid |
| enc_out_ready | input | 1 | Consumer takes code word |
| enc_word | output | 20 | Code word, MSB sent first |
| chk_in_valid | input | 1 | Received word valid |
| chk_in_ready | output | 1 | Checker can accept |
| chk_word_in | input | 20 | Received code word |
| chk_out_valid | output | 1 | Check result valid |
| chk_out_ready | input | 1 | Consumer takes result |
| chk_info | output | 12 | Information after correction |
| err_detected | output | 1 | Some check failed |
| err_corrected | output | 1 | Single bit located and handled |
| err_uncorr | output | 1 | Failure pattern not correctable |
| err_pos | output | 5 | Transmitted index of located bit |

## Verification
The encoder is driven with several information blocks: all zeros, all ones, a lone leading bit, a lone trailing bit and the R2 example. These separate a wrong row order from a wrong column order and from a missing corner bit.

The checker is first given the clean R2 word. It then receives that word with each of its twenty positions flipped in turn. This covers information bits, row-parity bits, column-parity bits and the corner, and shows that every flip is located at its own index.

Two bits flipped in one row, two in one column, and two on a diagonal exercise each uncorrectable branch. Holding the output ready low while the input changes shows that both stages keep their result.

// File: rtl/lvp_pkg.sv
package lvp_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_e;

    typedef struct packed {
        logic detected;
        logic corrected;
        logic uncorr;
    } err_flags_t;

endpackage

// File: rtl/lvp_stage.sv
module lvp_stage
    import lvp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    stage_state_e state_q;
    stage_state_e state_d;
    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_EMPTY && in_valid) begin
                data_q <= in_data;
            end
        end
    end

    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready = 1'b1;
                if (in_valid) state_d = ST_FULL;      // accept
            end
            ST_FULL: begin
                out_valid = 1'b1;
                if (out_ready) state_d = ST_EMPTY;    // release
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    assign out_data = data_q;

endmodule

// File: rtl/lvp_encoder.sv
module lvp_encoder #(
    parameter int ROWS = 3,
    parameter int COLS = 4,
    localparam int K = ROWS * COLS,
    localparam int N = (ROWS + 1) * (COLS + 1)
) (
    input  logic [K-1:0] info,
    output logic [N-1:0] word
);

    localparam int RW = COLS + 1;

    logic [ROWS-1:0] row_par;
    logic [COLS-1:0] col_par;

    always_comb begin
        row_par = '0;
        col_par = '0;
        word    = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                word[N-1-(r*RW+c)] = info[K-1-(r*COLS+c)];
                row_par[r] = row_par[r] ^ info[K-1-(r*COLS+c)];
                col_par[c] = col_par[c] ^ info[K-1-(r*COLS+c)];
            end
            word[N-1-(r*RW+COLS)] = row_par[r];
        end
        for (int c = 0; c < COLS; c++) begin
            word[N-1-(ROWS*RW+c)] = col_par[c];
        end
        word[0] = ^col_par;
    end

endmodule

// File: rtl/lvp_checker.sv
module lvp_checker
    import lvp_pkg::*;
#(
    parameter int ROWS = 3,
    parameter int COLS = 4,
    localparam int K  = ROWS * COLS,
    localparam int N  = (ROWS + 1) * (COLS + 1),
    localparam int PW = $clog2(N)
) (
    input  logic [N-1:0]  rx,
    output logic [K-1:0]  info,
    output err_flags_t    flags,
    output logic [PW-1:0] pos
);

    localparam int RW = COLS + 1;

    logic [ROWS:0] row_fail;
    logic [COLS:0] col_fail;
    logic          single;
    int            loc_r;
    int            loc_c;

    always_comb begin
        row_fail = '0;
        col_fail = '0;
        for (int r = 0; r <= ROWS; r++) begin
            for (int c = 0; c <= COLS; c++) begin
                row_fail[r] = row_fail[r] ^ rx[N-1-(r*RW+c)];
                col_fail[c] = col_fail[c] ^ rx[N-1-(r*RW+c)];
            end
        end
        loc_r = 0;
        loc_c = 0;
        for (int r = 0; r <= ROWS; r++) begin
            if (row_fail[r]) loc_r = r;
        end
        for (int c = 0; c <= COLS; c++) begin
            if (col_fail[c]) loc_c = c;
        end
        single = ($countones(row_fail) == 1) && ($countones(col_fail) == 1);

        flags.detected  = (|row_fail) | (|col_fail);
        flags.corrected = single;
        flags.uncorr    = flags.detected & ~single;
        pos = single ? PW'(loc_r * RW + loc_c) : '0;

        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                info[K-1-(r*COLS+c)] = rx[N-1-(r*RW+c)]
                    ^ (single && loc_r == r && loc_c == c);
            end
        end
    end

endmodule

// File: rtl/lvp_codec.sv
module lvp_codec
    import lvp_pkg::*;
#(
    parameter int ROWS = 3,
    parameter int COLS = 4,
    localparam int K  = ROWS * COLS,
    localparam int N  = (ROWS + 1) * (COLS + 1),
    localparam int PW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enc_in_valid,
    output logic          enc_in_ready,
    input  logic [K-1:0]  enc_info,
    output logic          enc_out_valid,
    input  logic          enc_out_ready,
    output logic [N-1:0]  enc_word,
    input  logic          chk_in_valid,
    output logic          chk_in_ready,
    input  logic [N-1:0]  chk_word_in,
    output logic          chk_out_valid,
    input  logic          chk_out_ready,
    output logic [K-1:0]  chk_info,
    output logic          err_detected,
    output logic          err_corrected,
    output logic          err_uncorr,
    output logic [PW-1:0] err_pos
);

    localparam int RES_W = K + 3 + PW;

    logic [N-1:0]     enc_comb;
    logic [K-1:0]     chk_info_comb;
    err_flags_t       chk_flags_comb;
    logic [PW-1:0]    chk_pos_comb;
    logic [RES_W-1:0] chk_res_q;

    lvp_encoder #(.ROWS(ROWS), .COLS(COLS)) u_enc (
        .info (enc_info),
        .word (enc_comb)
    );

    lvp_stage #(.W(N)) u_enc_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (enc_in_valid),
        .in_ready  (enc_in_ready),
        .in_data   (enc_comb),
        .out_valid (enc_out_valid),
        .out_ready (enc_out_ready),
        .out_data  (enc_word)
    );

    lvp_checker #(.ROWS(ROWS), .COLS(COLS)) u_chk_logic (
        .rx    (chk_word_in),
        .info  (chk_info_comb),
        .flags (chk_flags_comb),
        .pos   (chk_pos_comb)
    );

    lvp_stage #(.W(RES_W)) u_chk_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (chk_in_valid),
        .in_ready  (chk_in_ready),
        .in_data   ({chk_info_comb, chk_flags_comb, chk_pos_comb}),
        .out_valid (chk_out_valid),
        .out_ready (chk_out_ready),
        .out_data  (chk_res_q)
    );

    assign {chk_info, err_detected, err_corrected, err_uncorr, err_pos} = chk_res_q;

endmodule

// File: rtl/lvp_codec_chk.sv
module lvp_codec_chk #(
    parameter int ROWS = 3,
    parameter int COLS = 4,
    localparam int K  = ROWS * COLS,
    localparam int N  = (ROWS + 1) * (COLS + 1),
    localparam int PW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enc_in_valid,
    input logic          enc_in_ready,
    input logic          enc_out_valid,
    input logic          enc_out_ready,
    input logic [N-1:0]  enc_word,
    input logic          chk_in_valid,
    input logic          chk_in_ready,
    input logic          chk_out_valid,
    input logic          chk_out_ready,
    input logic [K-1:0]  chk_info,
    input logic          err_detected,
    input logic          err_corrected,
    input logic          err_uncorr,
    input logic [PW-1:0] err_pos
);

    p_enc_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
        enc_out_valid |-> (^enc_word) == 1'b0);

    p_enc_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_in_valid && enc_in_ready) |=> enc_out_valid);

    p_enc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_out_valid && !enc_out_ready) |=> (enc_out_valid && $stable(enc_word)));

    p_enc_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        enc_out_valid |-> !enc_in_ready);

    p_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_out_valid && !err_detected) |-> (err_pos == '0 && !err_corrected && !err_uncorr));

    p_fixed_detect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_out_valid && err_corrected) |-> err_detected);

    p_uncorr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_out_valid && err_uncorr) |-> (err_detected && !err_corrected && err_pos == '0));

    p_chk_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_in_valid && chk_in_ready) |=> chk_out_valid);

    p_chk_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_out_valid && !chk_out_ready) |=>
            (chk_out_valid && $stable(chk_info) && $stable(err_pos)));

    p_chk_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        chk_out_valid |-> !chk_in_ready);

endmodule

bind lvp_codec lvp_codec_chk #(.ROWS(ROWS), .COLS(COLS)) u_codec_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enc_in_valid  (enc_in_valid),
    .enc_in_ready  (enc_in_ready),
    .enc_out_valid (enc_out_valid),
    .enc_out_ready (enc_out_ready),
    .enc_word      (enc_word),
    .chk_in_valid  (chk_in_valid),
    .chk_in_ready  (chk_in_ready),
    .chk_out_valid (chk_out_valid),
    .chk_out_ready (chk_out_ready),
    .chk_info      (chk_info),
    .err_detected  (err_detected),
    .err_corrected (err_corrected),
    .err_uncorr    (err_uncorr),
    .err_pos       (err_pos)
);

// File: tb/lvp_codec_tb.sv
module lvp_codec_tb_top;

    localparam int ROWS = 3;
    localparam int COLS = 4;
    localparam int K  = ROWS * COLS;
    localparam int N  = (ROWS + 1) * (COLS + 1);
    localparam int PW = $clog2(N);

    localparam logic [11:0] EX_INFO = 12'b101101101011;
    localparam logic [19:0] EX_WORD = 20'b10111_01100_10111_01100;

    // {info, expected code word}
    localparam logic [31:0] ENC_TAB [5] = '{
        {12'b000000000000, 20'b00000_00000_00000_00000},
        {EX_INFO,          EX_WORD},
        {12'b111111111111, 20'b11110_11110_11110_11110},
        {12'b100000000000, 20'b10001_00000_00000_10001},
        {12'b000000000001, 20'b00000_00000_00011_00011}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enc_in_valid = 1'b0;
    logic          enc_in_ready;
    logic [K-1:0]  enc_info = '0;
    logic          enc_out_valid;
    logic          enc_out_ready = 1'b0;
    logic [N-1:0]  enc_word;
    logic          chk_in_valid = 1'b0;
    logic          chk_in_ready;
    logic [N-1:0]  chk_word_in = '0;
    logic          chk_out_valid;
    logic          chk_out_ready = 1'b0;
    logic [K-1:0]  chk_info;
    logic          err_detected;
    logic          err_corrected;
    logic          err_uncorr;
    logic [PW-1:0] err_pos;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lvp_codec #(.ROWS(ROWS), .COLS(COLS)) dut_i (.*);

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_enc(input logic [K-1:0] info, input logic [N-1:0] exp, input string req);
        @(negedge clk);
        check("R3", "enc_in_ready before send", 32'(enc_in_ready), 32'd1);
        enc_info = info;
        enc_in_valid = 1'b1;
        @(negedge clk);
        enc_in_valid = 1'b0;
        check("R3", "enc_out_valid one cycle after", 32'(enc_out_valid), 32'd1);
        check(req, "enc_word", 32'(enc_word), 32'(exp));
        enc_out_ready = 1'b1;
        @(negedge clk);
        enc_out_ready = 1'b0;
    endtask

    task automatic do_chk(input logic [N-1:0] w, input logic [K-1:0] exp_info,
                          input logic det, input logic cor, input logic unc,
                          input logic [PW-1:0] pos, input string req);
        @(negedge clk);
        chk_word_in = w;
        chk_in_valid = 1'b1;
        @(negedge clk);
        chk_in_valid = 1'b0;
        check("R9", "chk_out_valid one cycle after", 32'(chk_out_valid), 32'd1);
        check(req, "chk_info", 32'(chk_info), 32'(exp_info));
        check(req, "flags det/cor/unc", {29'd0, err_detected, err_corrected, err_uncorr},
              {29'd0, det, cor, unc});
        check(req, "err_pos", 32'(err_pos), 32'(pos));
        chk_out_ready = 1'b1;
        @(negedge clk);
        chk_out_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "enc_in_ready in reset", 32'(enc_in_ready), 32'd1);
        check("R10", "chk_in_ready in reset", 32'(chk_in_ready), 32'd1);
        check("R10", "enc_out_valid in reset", 32'(enc_out_valid), 32'd0);
        check("R10", "chk_out_valid in reset", 32'(chk_out_valid), 32'd0);
        rst_n = 1'b1;

        // R1, R2: encoder table
        for (int i = 0; i < 5; i++) begin
            do_enc(ENC_TAB[i][31:20], ENC_TAB[i][19:0], (i == 1) ? "R2" : "R1");
        end

        // R3: output held while ready low, new input ignored
        @(negedge clk);
        enc_info = EX_INFO;
        enc_in_valid = 1'b1;
        @(negedge clk);
        enc_info = 12'hFFF;
        @(negedge clk);
        check("R3", "in_ready low while full", 32'(enc_in_ready), 32'd0);
        check("R3", "valid held", 32'(enc_out_valid), 32'd1);
        check("R3", "word held", 32'(enc_word), 32'(EX_WORD));
        enc_in_valid = 1'b0;
        enc_out_ready = 1'b1;
        @(negedge clk);
        enc_out_ready = 1'b0;
        check("R3", "valid drops after release", 32'(enc_out_valid), 32'd0);

        // R4: clean word
        do_chk(EX_WORD, EX_INFO, 1'b0, 1'b0, 1'b0, '0, "R4");

        // R5 / R6 / R7: each single flip at transmitted index t
        for (int t = 0; t < N; t++) begin
            string req;
            if (t == N - 1) req = "R7";
            else if ((t % (COLS + 1)) == COLS || (t / (COLS + 1)) == ROWS) req = "R6";
            else req = "R5";
            do_chk(EX_WORD ^ (20'd1 << (N - 1 - t)), EX_INFO, 1'b1, 1'b1, 1'b0, PW'(t), req);
        end

        // R8: two flips in one row (only columns fail): indices 0 and 1
        do_chk(EX_WORD ^ 20'b11000_00000_00000_00000, 12'b011101101011,
               1'b1, 1'b0, 1'b1, '0, "R8");
        // R8: two flips in one column (only rows fail): indices 0 and 5
        do_chk(EX_WORD ^ 20'b10000_10000_00000_00000, 12'b001111101011,
               1'b1, 1'b0, 1'b1, '0, "R8");
        // R8: diagonal flips (two rows and two columns fail): indices 0 and 6
        do_chk(EX_WORD ^ 20'b10000_01000_00000_00000, 12'b001100101011,
               1'b1, 1'b0, 1'b1, '0, "R8");

        // R9: result held while ready low
        @(negedge clk);
        chk_word_in = EX_WORD ^ 20'b00000_00100_00000_00000;
        chk_in_valid = 1'b1;
        @(negedge clk);
        chk_word_in = '0;
        @(negedge clk);
        check("R9", "chk_in_ready low while full", 32'(chk_in_ready), 32'd0);
        check("R9", "chk_info held", 32'(chk_info), 32'(EX_INFO));
        check("R9", "err_pos held", 32'(err_pos), 32'd7);
        chk_in_valid = 1'b0;
        chk_out_ready = 1'b1;
        @(negedge clk);
        chk_out_ready = 1'b0;

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule